// File: doc/BRIEF.md
# Paged Opcode Prefetch Decoder

This block sits between an instruction fetch port and an execution stage. It requests 16-bit instruction words from consecutive even byte addresses and keeps a word program counter that steps by two on every accepted word. The words go into a three-entry queue. From the head of that queue the block assembles one complete instruction at a time. Every instruction length is a whole number of words, so every instruction starts in the high byte of the queue head.

The head byte is checked against three prefix values that select opcode pages 1, 2 and 3. A prefix is removed from the output. The byte after it is always taken as the opcode, even when it has a prefix value. Without a prefix, the head byte is a page 0 opcode and the low byte of the same word is its first operand. The page and opcode go out on a lookup port. An external table returns the byte length and a nibble mode for that opcode. The block then issues the page, the opcode, up to four operand bytes, the operand count and the length over a valid/ready handshake.

A bad length raises a sticky error flag and blocks issue. A flush input reloads the program counter, empties the queue and clears the error flag, all in one cycle.

Top module: `pgop_prefetch`

## Requirements
- R1: After reset, `fetch_req_o` is 1, `fetch_addr_o` is 0x0100, and both `iss_valid_o` and `len_err_o` are 0.
- R2: `fetch_addr_o` rises by 2 after each cycle in which `fetch_req_o` and `fetch_ack_i` are both 1. It holds its value in every other cycle without a flush.
- R3: While the queue holds three words, `fetch_req_o` is 0.
- R4: A head word whose high byte is not 0x17, 0x27 or 0x37 is a page 0 instruction. The opcode is the high byte and operand 0 is the low byte. A looked-up length of 2 issues it as a one-word instruction with operand count 1.
- R5: A head high byte of 0x17, 0x27 or 0x37 gives page 1, 2 or 3. The low byte is the opcode, the prefix is dropped, and operands follow from the next words. `lk_page_o` and `lk_opcode_o` show the page and opcode of the queue head.
- R6: The byte after a prefix is always the opcode, even when its value is 0x17, 0x27 or 0x37.
- R7: `iss_valid_o` is 1 only when the queue holds all length/2 words of the head instruction. Issue outputs stay the same while `iss_ready_i` is 0. An issue removes exactly length/2 words.
- R8: A looked-up length that is zero, odd or above 6 bytes, or that gives more than 4 operand bytes, sets `len_err_o` one cycle after that head appears. Nothing issues while the flag is set, and it stays set until a flush.
- R9: A flush loads the program counter with `flush_addr_i` with bit 0 cleared. It also empties the queue and clears `len_err_o`. All of this takes effect in the next cycle.
- R10: With nibble mode 01 (zero-extend), operand 0 becomes {4'h0, low nibble of the first operand byte}.
- R11: With nibble mode 10 (packed), the first operand byte splits into operand 0 = {4'h0, high nibble} and operand 1 = {4'h0, low nibble}. The later operand bytes move up one slot, and the count rises by one.
- R12: Operand slots at or above the operand count are zero. Operand 0 is in bits 7:0 of `iss_opnd_o`.
- R13: The queue can hold three one-word instructions at once. They issue in fetch order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Redirect: reload the program counter, empty the queue, clear the error |
| flush_addr_i | input | 16 | New fetch byte address (bit 0 ignored) |
| fetch_req_o | output | 1 | Fetch request valid |
| fetch_addr_o | output | 16 | Byte address of the requested word |
| fetch_ack_i | input | 1 | Fetch ready; `fetch_data_i` is taken when both are 1 |
| fetch_data_i | input | 16 | Fetched word, first byte in bits 15:8 |
| lk_page_o | output | 2 | Page of the queue head instruction |
| lk_opcode_o | output | 8 | Opcode of the queue head instruction |
| lk_len_i | input | 4 | Instruction length in bytes from the lookup |
| lk_mode_i | input | 2 | Nibble mode: 00 raw, 01 zero-extend, 10 packed, 11 raw |
| iss_valid_o | output | 1 | Complete instruction available |
| iss_ready_i | input | 1 | Execution stage accepts the instruction |
| iss_page_o | output | 2 | Issued page |
| iss_opcode_o | output | 8 | Issued opcode |
| iss_opnd_o | output | 32 | Operand bytes, operand 0 in bits 7:0 |
| iss_opcnt_o | output | 3 | Number of valid operand bytes |
| iss_len_o | output | 4 | Instruction length in bytes |
| len_err_o | output | 1 | Sticky length error |

## Verification
A word accepted at a clock edge is in the queue right after that edge. The lookup outputs and `iss_valid_o` follow from queue state through logic only. Issue results are therefore due in the cycle that follows the edge that accepted the last word. The length error needs one more edge and is due a cycle later. Flush effects and queue removal after an issue are each due in the cycle after their edge. The bench changes inputs and samples outputs only on falling edges. Each check is placed on the falling edge that follows the due clock edge, with the number of edges counted explicitly in every task.

// File: rtl/pgop_pkg.sv
// Shared constants, types and helpers for the paged opcode prefetch decoder.
// Assumes big-endian byte order inside a fetched 16-bit word.
package pgop_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    // Prefix values that select the non-zero opcode pages
    localparam logic [BYTE_W-1:0] PFX_PAGE1 = 8'h17;
    localparam logic [BYTE_W-1:0] PFX_PAGE2 = 8'h27;
    localparam logic [BYTE_W-1:0] PFX_PAGE3 = 8'h37;

    typedef enum logic [1:0] {
        NIB_RAW  = 2'b00,
        NIB_ZEXT = 2'b01,
        NIB_PACK = 2'b10,
        NIB_RSVD = 2'b11
    } nib_mode_e;

    typedef struct packed {
        logic       hit;
        logic [1:0] page;
    } pfx_info_t;

    // Classify a leading byte as a page prefix or not
    function automatic pfx_info_t prefix_decode(input logic [BYTE_W-1:0] b);
        pfx_info_t r;
        case (b)
            PFX_PAGE1: r = '{hit: 1'b1, page: 2'd1};
            PFX_PAGE2: r = '{hit: 1'b1, page: 2'd2};
            PFX_PAGE3: r = '{hit: 1'b1, page: 2'd3};
            default:   r = '{hit: 1'b0, page: 2'd0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pgop_pc.sv
// Word program counter and fetch request generator.
// Assumes: the request is raised whenever the queue has room and no flush is
// active; a word is taken when request and acknowledge are both high.
module pgop_pc #(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [ADDR_W-1:0] flush_addr_i,
    input  logic              room_i,
    input  logic              ack_i,
    output logic              req_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              push_o
);

    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] EVEN_MSK = ~ADDR_W'(1);

    logic [ADDR_W-1:0] pc_q;

    assign req_o  = room_i && !flush_i;
    assign push_o = req_o && ack_i;
    assign addr_o = pc_q;

    // Program counter: reset value, flush reload, or step per accepted word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_ADDR & EVEN_MSK;
        end else if (flush_i) begin
            pc_q <= flush_addr_i & EVEN_MSK;
        end else if (push_o) begin
            pc_q <= pc_q + STEP;
        end
    end

endmodule

// File: rtl/pgop_wordq.sv
// Shifting word queue, head at entry 0.
// Assumes: a push is never offered when full; the pop count never exceeds
// the current fill level; clear wins over push and pop.
module pgop_wordq #(
    parameter int DEPTH  = 3,
    parameter int WORD_W = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear_i,
    input  logic                         push_i,
    input  logic [WORD_W-1:0]            push_word_i,
    input  logic [CNT_W-1:0]             pop_n_i,
    output logic [DEPTH-1:0][WORD_W-1:0] words_o,
    output logic [CNT_W-1:0]             cnt_o,
    output logic                         room_o
);

    logic [DEPTH-1:0][WORD_W-1:0] ent_q;
    logic [DEPTH-1:0][WORD_W-1:0] ent_d;
    logic [CNT_W-1:0]             cnt_q;
    logic [CNT_W-1:0]             cnt_d;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [WORD_W-1:0] nxt;
        // Select the word that lands in entry i after pop and push
        always_comb begin
            nxt = '0;
            for (int j = 0; j < DEPTH; j++) begin
                if (j == i + int'(pop_n_i)) nxt = ent_q[j];
            end
            if (push_i && (i == int'(cnt_q) - int'(pop_n_i))) nxt = push_word_i;
        end
        assign ent_d[i] = nxt;
    end

    // Next fill level
    always_comb begin
        cnt_d = cnt_q - pop_n_i + CNT_W'(push_i);
    end

    // Queue storage and fill level registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '0;
            cnt_q <= '0;
        end else if (clear_i) begin
            ent_q <= '0;
            cnt_q <= '0;
        end else begin
            ent_q <= ent_d;
            cnt_q <= cnt_d;
        end
    end

    assign words_o = ent_q;
    assign cnt_o   = cnt_q;
    assign room_o  = int'(cnt_q) < DEPTH;

endmodule

// File: rtl/pgop_split.sv
// Instruction assembler: finds the page prefix, the opcode and the operand
// bytes in the queued words, checks the looked-up length and unpacks nibbles.
// Assumes: instructions start at the high byte of queue entry 0; lookup
// inputs are combinational answers for the page and opcode driven out here.
module pgop_split #(
    parameter int DEPTH   = 3,
    parameter int MAX_LEN = 6,
    parameter int OPND_N  = 4,
    parameter int LEN_W   = 4,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int OPC_W  = $clog2(OPND_N + 1)
) (
    input  logic [DEPTH-1:0][15:0]  words_i,
    input  logic [CNT_W-1:0]        cnt_i,
    input  logic [LEN_W-1:0]        len_i,
    input  logic [1:0]              mode_i,
    output logic [1:0]              page_o,
    output logic [7:0]              opcode_o,
    output logic [OPND_N-1:0][7:0]  opnd_o,
    output logic [OPC_W-1:0]        opcnt_o,
    output logic [CNT_W-1:0]        nwords_o,
    output logic                    present_o,
    output logic                    len_bad_o,
    output logic                    issue_ok_o
);

    import pgop_pkg::*;

    localparam int NBYTES = DEPTH * 2;

    logic [NBYTES-1:0][7:0] stream;
    logic [OPND_N-1:0][7:0] raw_pfx;
    logic [OPND_N-1:0][7:0] raw_p0;
    logic [OPND_N-1:0][7:0] raw;
    logic [OPND_N-1:0][7:0] shf;
    pfx_info_t              pfx;
    int                     hdr;
    int                     n_raw;
    int                     n_out;
    nib_mode_e              mode;

    // Flatten queued words into a byte stream, first byte at index 0
    for (genvar w = 0; w < DEPTH; w++) begin : g_bytes
        assign stream[2*w]   = words_i[w][15:8];
        assign stream[2*w+1] = words_i[w][7:0];
    end

    assign pfx      = prefix_decode(stream[0]);
    assign page_o   = pfx.page;
    assign opcode_o = pfx.hit ? stream[1] : stream[0];
    assign mode     = nib_mode_e'(mode_i);

    // Candidate operand bytes for the prefixed and the page 0 forms
    for (genvar j = 0; j < OPND_N; j++) begin : g_raw
        if (j + 2 < NBYTES) begin : g_pfx_in
            assign raw_pfx[j] = stream[j+2];
        end else begin : g_pfx_out
            assign raw_pfx[j] = '0;
        end
        if (j + 1 < NBYTES) begin : g_p0_in
            assign raw_p0[j] = stream[j+1];
        end else begin : g_p0_out
            assign raw_p0[j] = '0;
        end
        assign raw[j] = pfx.hit ? raw_pfx[j] : raw_p0[j];
        if (j >= 1) begin : g_shf
            assign shf[j] = raw[j-1];
        end else begin : g_shf0
            assign shf[j] = '0;
        end
    end

    // Operand counting and length legality
    always_comb begin
        hdr   = pfx.hit ? 2 : 1;
        n_raw = int'(len_i) - hdr;
        n_out = (mode == NIB_PACK && n_raw > 0) ? n_raw + 1 : n_raw;
        len_bad_o = (len_i == '0) || len_i[0] || (int'(len_i) > MAX_LEN)
                    || (n_out > OPND_N);
    end

    // Per-slot nibble handling and zeroing of unused slots
    for (genvar j = 0; j < OPND_N; j++) begin : g_out
        logic [7:0] val;
        always_comb begin
            case (mode)
                NIB_ZEXT: val = (j == 0) ? {4'h0, raw[0][3:0]} : raw[j];
                NIB_PACK: val = (j == 0) ? {4'h0, raw[0][7:4]}
                              : (j == 1) ? {4'h0, raw[0][3:0]} : shf[j];
                default:  val = raw[j];
            endcase
        end
        assign opnd_o[j] = (j < n_out) ? val : 8'h00;
    end

    assign opcnt_o    = (n_out < 0 || len_bad_o) ? '0 : OPC_W'(n_out);
    assign nwords_o   = CNT_W'(len_i >> 1);
    assign present_o  = cnt_i != '0;
    assign issue_ok_o = present_o && !len_bad_o && (cnt_i >= nwords_o);

endmodule

// File: rtl/pgop_prefetch.sv
// Top of the paged opcode prefetch decoder: program counter, word queue,
// instruction assembler and the sticky length error flag.
// Assumes: the opcode length table is external and answers combinationally.
module pgop_prefetch #(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 16'h0100,
    parameter int                Q_DEPTH    = 3,
    parameter int                MAX_LEN    = 6,
    parameter int                OPND_N     = 4,
    parameter int                LEN_W      = 4,
    localparam int               OPC_W      = $clog2(OPND_N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [ADDR_W-1:0] flush_addr_i,
    output logic              fetch_req_o,
    output logic [ADDR_W-1:0] fetch_addr_o,
    input  logic              fetch_ack_i,
    input  logic [15:0]       fetch_data_i,
    output logic [1:0]        lk_page_o,
    output logic [7:0]        lk_opcode_o,
    input  logic [LEN_W-1:0]  lk_len_i,
    input  logic [1:0]        lk_mode_i,
    output logic              iss_valid_o,
    input  logic              iss_ready_i,
    output logic [1:0]        iss_page_o,
    output logic [7:0]        iss_opcode_o,
    output logic [OPND_N*8-1:0] iss_opnd_o,
    output logic [OPC_W-1:0]  iss_opcnt_o,
    output logic [LEN_W-1:0]  iss_len_o,
    output logic              len_err_o
);

    localparam int CNT_W = $clog2(Q_DEPTH + 1);

    logic                          push;
    logic                          room;
    logic [Q_DEPTH-1:0][15:0]      q_words;
    logic [CNT_W-1:0]              q_cnt;
    logic [CNT_W-1:0]              pop_n;
    logic [CNT_W-1:0]              nwords;
    logic [1:0]                    page;
    logic [7:0]                    opcode;
    logic [OPND_N-1:0][7:0]        opnd;
    logic [OPC_W-1:0]              opcnt;
    logic                          present;
    logic                          len_bad;
    logic                          issue_ok;
    logic                          err_q;
    logic                          fire;

    pgop_pc #(
        .ADDR_W     (ADDR_W),
        .RESET_ADDR (RESET_ADDR)
    ) u_pc (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush_i),
        .flush_addr_i (flush_addr_i),
        .room_i       (room),
        .ack_i        (fetch_ack_i),
        .req_o        (fetch_req_o),
        .addr_o       (fetch_addr_o),
        .push_o       (push)
    );

    pgop_wordq #(
        .DEPTH  (Q_DEPTH),
        .WORD_W (16)
    ) u_q (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (flush_i),
        .push_i      (push),
        .push_word_i (fetch_data_i),
        .pop_n_i     (pop_n),
        .words_o     (q_words),
        .cnt_o       (q_cnt),
        .room_o      (room)
    );

    pgop_split #(
        .DEPTH   (Q_DEPTH),
        .MAX_LEN (MAX_LEN),
        .OPND_N  (OPND_N),
        .LEN_W   (LEN_W)
    ) u_split (
        .words_i    (q_words),
        .cnt_i      (q_cnt),
        .len_i      (lk_len_i),
        .mode_i     (lk_mode_i),
        .page_o     (page),
        .opcode_o   (opcode),
        .opnd_o     (opnd),
        .opcnt_o    (opcnt),
        .nwords_o   (nwords),
        .present_o  (present),
        .len_bad_o  (len_bad),
        .issue_ok_o (issue_ok)
    );

    // Sticky length error: set on an illegal head, cleared only by flush
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (flush_i) begin
            err_q <= 1'b0;
        end else if (present && len_bad) begin
            err_q <= 1'b1;
        end
    end

    assign iss_valid_o  = issue_ok && !err_q && !flush_i;
    assign fire         = iss_valid_o && iss_ready_i;
    assign pop_n        = fire ? nwords : '0;

    assign lk_page_o    = page;
    assign lk_opcode_o  = opcode;
    assign iss_page_o   = page;
    assign iss_opcode_o = opcode;
    assign iss_opnd_o   = opnd;
    assign iss_opcnt_o  = opcnt;
    assign iss_len_o    = lk_len_i;
    assign len_err_o    = err_q;

endmodule

// File: rtl/pgop_prefetch_chk.sv
// Property checker for pgop_prefetch, attached with bind below.
// Assumes: q_cnt is the queue fill level inside the top module.
module pgop_prefetch_chk #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 3,
    parameter int CNT_W  = 2,
    parameter int LEN_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush_i,
    input logic [ADDR_W-1:0] flush_addr_i,
    input logic              fetch_req_o,
    input logic              fetch_ack_i,
    input logic [ADDR_W-1:0] fetch_addr_o,
    input logic              iss_valid_o,
    input logic              iss_ready_i,
    input logic [1:0]        iss_page_o,
    input logic [7:0]        iss_opcode_o,
    input logic [LEN_W-1:0]  iss_len_o,
    input logic              len_err_o,
    input logic [CNT_W-1:0]  q_cnt
);

    localparam logic [ADDR_W-1:0] EVEN_MSK = ~ADDR_W'(1);

    p_no_req_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(q_cnt) >= DEPTH) |-> !fetch_req_o);

    p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_o && fetch_ack_i && !flush_i)
        |=> (fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(2)));

    p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(fetch_req_o && fetch_ack_i) && !flush_i) |=> $stable(fetch_addr_o));

    p_flush_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (fetch_addr_o == ($past(flush_addr_i) & EVEN_MSK)));

    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (q_cnt == '0) && !len_err_o);

    p_err_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        len_err_o |-> !iss_valid_o);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (len_err_o && !flush_i) |=> len_err_o);

    p_complete_r7: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid_o |-> (int'(q_cnt) >= int'(iss_len_o) / 2));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid_o && !iss_ready_i && !flush_i)
        |=> flush_i || (iss_valid_o && $stable(iss_opcode_o) && $stable(iss_page_o)));

endmodule

bind pgop_prefetch pgop_prefetch_chk #(
    .ADDR_W (ADDR_W),
    .DEPTH  (Q_DEPTH),
    .CNT_W  (CNT_W),
    .LEN_W  (LEN_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (flush_i),
    .flush_addr_i (flush_addr_i),
    .fetch_req_o  (fetch_req_o),
    .fetch_ack_i  (fetch_ack_i),
    .fetch_addr_o (fetch_addr_o),
    .iss_valid_o  (iss_valid_o),
    .iss_ready_i  (iss_ready_i),
    .iss_page_o   (iss_page_o),
    .iss_opcode_o (iss_opcode_o),
    .iss_len_o    (iss_len_o),
    .len_err_o    (len_err_o),
    .q_cnt        (q_cnt)
);

// File: tb/pgop_prefetch_test.sv
// Directed bench for pgop_prefetch; inputs change and outputs are sampled on
// falling edges only.
module pgop_prefetch_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic [15:0] flush_addr_i = '0;
    logic        fetch_req_o;
    logic [15:0] fetch_addr_o;
    logic        fetch_ack_i;
    logic [15:0] fetch_data_i;
    logic [1:0]  lk_page_o;
    logic [7:0]  lk_opcode_o;
    logic [3:0]  lk_len_i;
    logic [1:0]  lk_mode_i;
    logic        iss_valid_o;
    logic        iss_ready_i = 1'b0;
    logic [1:0]  iss_page_o;
    logic [7:0]  iss_opcode_o;
    logic [31:0] iss_opnd_o;
    logic [2:0]  iss_opcnt_o;
    logic [3:0]  iss_len_o;
    logic        len_err_o;

    logic        ack_en = 1'b0;
    logic [15:0] mem     [0:255];
    logic [3:0]  len_tab [0:1023];
    logic [1:0]  mode_tab[0:1023];

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    assign fetch_ack_i  = ack_en;
    assign fetch_data_i = mem[fetch_addr_o[8:1]];
    assign lk_len_i     = len_tab[{lk_page_o, lk_opcode_o}];
    assign lk_mode_i    = mode_tab[{lk_page_o, lk_opcode_o}];

    pgop_prefetch uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush_i),
        .flush_addr_i (flush_addr_i),
        .fetch_req_o  (fetch_req_o),
        .fetch_addr_o (fetch_addr_o),
        .fetch_ack_i  (fetch_ack_i),
        .fetch_data_i (fetch_data_i),
        .lk_page_o    (lk_page_o),
        .lk_opcode_o  (lk_opcode_o),
        .lk_len_i     (lk_len_i),
        .lk_mode_i    (lk_mode_i),
        .iss_valid_o  (iss_valid_o),
        .iss_ready_i  (iss_ready_i),
        .iss_page_o   (iss_page_o),
        .iss_opcode_o (iss_opcode_o),
        .iss_opnd_o   (iss_opnd_o),
        .iss_opcnt_o  (iss_opcnt_o),
        .iss_len_o    (iss_len_o),
        .len_err_o    (len_err_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic exp_issue(input string req, input logic [1:0] pg, input logic [7:0] op,
                             input logic [31:0] opnd, input int cnt);
        chk({req, " valid"},  32'(iss_valid_o), 32'd1);
        chk({req, " page"},   32'(iss_page_o), 32'(pg));
        chk({req, " opcode"}, 32'(iss_opcode_o), 32'(op));
        chk({req, " opnd"},   iss_opnd_o, opnd);
        chk({req, " opcnt"},  32'(iss_opcnt_o), 32'(cnt));
    endtask

    // Flush to address a; ends on the falling edge after the flush edge
    task automatic do_flush(input logic [15:0] a);
        ack_en = 1'b0;
        iss_ready_i = 1'b0;
        flush_i = 1'b1;
        flush_addr_i = a;
        @(negedge clk);
        flush_i = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 req",   32'(fetch_req_o), 32'd1);
        chk("R1 addr",  32'(fetch_addr_o), 32'h0100);
        chk("R1 valid", 32'(iss_valid_o), 32'd0);
        chk("R1 err",   32'(len_err_o), 32'd0);
    endtask

    task automatic t_one_word;
        do_flush(16'h0041);
        chk("R9 even reload", 32'(fetch_addr_o), 32'h0040);
        mem[8'h20] = 16'h4011;
        mem[8'h21] = 16'h4122;
        mem[8'h22] = 16'h4233;
        @(negedge clk);
        chk("R2 hold without ack", 32'(fetch_addr_o), 32'h0040);
        ack_en = 1'b1;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            chk("R2 step", 32'(fetch_addr_o), 32'h0040 + 32'(2 * k));
        end
        chk("R3 full holds request", 32'(fetch_req_o), 32'd0);
        @(negedge clk);
        chk("R3 no step when full", 32'(fetch_addr_o), 32'h0046);
        ack_en = 1'b0;
        exp_issue("R4", 2'd0, 8'h40, 32'h0000_0011, 1);
        iss_ready_i = 1'b1;
        @(negedge clk);
        exp_issue("R13 second", 2'd0, 8'h41, 32'h0000_0022, 1);
        @(negedge clk);
        exp_issue("R13 third", 2'd0, 8'h42, 32'h0000_0033, 1);
        @(negedge clk);
        iss_ready_i = 1'b0;
        chk("R13 drained", 32'(iss_valid_o), 32'd0);
    endtask

    task automatic t_paged;
        do_flush(16'h0080);
        mem[8'h40] = 16'h1705;
        mem[8'h41] = 16'hAABB;
        mem[8'h42] = 16'hCCDD;
        len_tab[{2'd1, 8'h05}] = 4'd6;
        ack_en = 1'b1;
        @(negedge clk);
        chk("R5 lookup page", 32'(lk_page_o), 32'd1);
        chk("R5 lookup opcode", 32'(lk_opcode_o), 32'h05);
        chk("R7 one of three words", 32'(iss_valid_o), 32'd0);
        @(negedge clk);
        chk("R7 two of three words", 32'(iss_valid_o), 32'd0);
        @(negedge clk);
        ack_en = 1'b0;
        exp_issue("R5 page1 six bytes", 2'd1, 8'h05, 32'hDDCC_BBAA, 4);
        chk("R5 len", 32'(iss_len_o), 32'd6);
        @(negedge clk);
        exp_issue("R7 held while not ready", 2'd1, 8'h05, 32'hDDCC_BBAA, 4);
        iss_ready_i = 1'b1;
        @(negedge clk);
        iss_ready_i = 1'b0;
        chk("R7 three words removed", 32'(iss_valid_o), 32'd0);

        do_flush(16'h00A0);
        mem[8'h50] = 16'h2710;
        mem[8'h51] = 16'h3717;
        mem[8'h52] = 16'h1234;
        mem[8'h53] = 16'h1727;
        len_tab[{2'd2, 8'h10}] = 4'd2;
        len_tab[{2'd3, 8'h17}] = 4'd4;
        len_tab[{2'd1, 8'h27}] = 4'd2;
        ack_en = 1'b1;
        repeat (3) @(negedge clk);
        ack_en = 1'b0;
        exp_issue("R5 page2", 2'd2, 8'h10, 32'h0, 0);
        iss_ready_i = 1'b1;
        @(negedge clk);
        iss_ready_i = 1'b0;
        exp_issue("R6 page3 opcode 0x17", 2'd3, 8'h17, 32'h0000_3412, 2);
        iss_ready_i = 1'b1;
        @(negedge clk);
        iss_ready_i = 1'b0;
        chk("R7 two words removed", 32'(iss_valid_o), 32'd0);
        ack_en = 1'b1;
        @(negedge clk);
        ack_en = 1'b0;
        exp_issue("R6 page1 opcode 0x27", 2'd1, 8'h27, 32'h0, 0);
    endtask

    task automatic t_len_err;
        logic [7:0] ops [4] = '{8'h60, 8'h61, 8'h62, 8'h63};
        logic [3:0] lens[4] = '{4'd3, 4'd6, 4'd0, 4'd8};
        for (int k = 0; k < 4; k++) begin
            do_flush(16'h00C0);
            mem[8'h60] = {ops[k], 8'h01};
            len_tab[{2'd0, ops[k]}] = lens[k];
            ack_en = 1'b1;
            @(negedge clk);
            ack_en = 1'b0;
            chk("R8 no issue on bad length", 32'(iss_valid_o), 32'd0);
            iss_ready_i = 1'b1;
            @(negedge clk);
            chk("R8 error raised", 32'(len_err_o), 32'd1);
            chk("R8 blocked", 32'(iss_valid_o), 32'd0);
            @(negedge clk);
            chk("R8 error sticky", 32'(len_err_o), 32'd1);
            iss_ready_i = 1'b0;
            do_flush(16'h00C0);
            chk("R9 error cleared", 32'(len_err_o), 32'd0);
            chk("R9 queue emptied", 32'(iss_valid_o), 32'd0);
        end
    endtask

    task automatic t_nibble;
        do_flush(16'h00E0);
        mem[8'h70] = 16'h50A7;
        mem[8'h71] = 16'h51A7;
        mem[8'h72] = 16'h52C3;
        mem[8'h73] = 16'h9E00;
        len_tab[{2'd0, 8'h50}] = 4'd2;  mode_tab[{2'd0, 8'h50}] = 2'b01;
        len_tab[{2'd0, 8'h51}] = 4'd2;  mode_tab[{2'd0, 8'h51}] = 2'b10;
        len_tab[{2'd0, 8'h52}] = 4'd4;  mode_tab[{2'd0, 8'h52}] = 2'b10;
        ack_en = 1'b1;
        repeat (3) @(negedge clk);
        ack_en = 1'b0;
        exp_issue("R10 zero-extend, R12 upper zero", 2'd0, 8'h50, 32'h0000_0007, 1);
        iss_ready_i = 1'b1;
        @(negedge clk);
        iss_ready_i = 1'b0;
        exp_issue("R11 packed", 2'd0, 8'h51, 32'h0000_070A, 2);
        iss_ready_i = 1'b1;
        @(negedge clk);
        iss_ready_i = 1'b0;
        chk("R7 partial two-word instruction", 32'(iss_valid_o), 32'd0);
        ack_en = 1'b1;
        @(negedge clk);
        ack_en = 1'b0;
        exp_issue("R11 packed shift", 2'd0, 8'h52, 32'h009E_030C, 4);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int i = 0; i < 1024; i++) begin
            len_tab[i]  = 4'd2;
            mode_tab[i] = 2'b00;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_one_word();
        t_paged();
        t_len_err();
        t_nibble();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule